// File: doc/BRIEF.md
# Vector Element Register Packer

This block sits behind a vector load unit and turns a stream of loaded elements into writes on a 64-bit-wide register file. It is given a base register, a vector length, an element width of 64, 32, 16 or 8 bits, and three flags: big-endian mode, byte-reversed load and reverse element order. It then accepts one element per handshake.

For each element the block works out the target register and the byte lanes the element occupies. Narrow elements are packed several to a register, starting at the low lanes. Where the mode calls for it, the bytes inside each element are swapped at the element's own width, never across the whole register. Each element becomes one write that carries a byte-enable mask, so the other elements already in a partly filled register are left alone. A one-cycle done pulse closes the operation.

Element positions depend only on the width and the element index. A later read at the same width therefore finds the elements in the order in which they were indexed.

Top module: `vec_elem_packer`

## Requirements
- R1: The width code `elem_width` selects the element size: 0 for 64 bits, 1 for 32, 2 for 16 and 3 for 8. At 64 bits, element i is written to register base+i with all eight byte enables set.
- R2: At 32 bits, element i goes to register base+i/2. Even elements occupy bits 31:0 (byte enables 8'h0F) and odd elements occupy bits 63:32 (8'hF0).
- R3: At 16 and 8 bits, a register holds 4 and 8 elements respectively. Element i with width w goes to register base+(i*w)/64, starting at bit (i*w) mod 64.
- R4: `wr_be` sets exactly the byte lanes of the element being written. Bit b enables bits 8b+7:8b. The element value, taken from the low w bits of `elem_data`, appears in those lanes of `wr_data`. Bits of `elem_data` above w have no effect.
- R5: The bytes of an element are reversed within its own width when `big_endian` XOR `byte_rev_ld` is 1. Otherwise they are stored in order.
- R6: With `rev_order` low, the k-th accepted element gets index k. With it high, the k-th accepted element gets index VL-1-k. Reading the register file back at the same width returns each element at the position of its index.
- R7: The register number wraps modulo 128.
- R8: `elem_ready` is high only while the block is collecting elements. Each cycle with `elem_valid` and `elem_ready` both high produces exactly one write, with `wr_en` high in the next cycle. No write happens without a handshake.
- R9: `done` is high for exactly one cycle, the cycle after the write of the last element. With VL of 0 there are no writes, and `done` is high in the cycle after `start` is sampled.
- R10: The configuration is captured when `start` is sampled while idle. `start` and changes on the configuration inputs have no effect while an operation is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| base_reg | input | 7 | First destination register |
| vec_len | input | 7 | Number of elements, 0 to 64 |
| elem_width | input | 2 | Width code: 0=64, 1=32, 2=16, 3=8 bits |
| big_endian | input | 1 | Big-endian mode |
| byte_rev_ld | input | 1 | Byte-reversed load; inverts the swap decision |
| rev_order | input | 1 | Process elements from VL-1 down to 0 |
| elem_valid | input | 1 | Element data valid |
| elem_data | input | 64 | Element value in the low bits |
| elem_ready | output | 1 | Block accepts an element this cycle |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 7 | Register number written |
| wr_data | output | 64 | Write data, element placed in its lanes |
| wr_be | output | 8 | Byte enables of the write |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions take it for granted that `vec_len` never exceeds 64 when an operation is started. They also accept that `elem_valid` may drop between elements at any time and that the upper bits of `elem_data` may carry junk. The stimulus keeps every vector length within 0 to 64 and fills the unused upper bits with nonzero patterns. It inserts idle cycles between elements and pulses `start` with a different configuration in the middle of some operations. Expected register, lane and data values are computed arithmetically, and each destination register is read back from a bench-side register-file model.

// File: rtl/vpk_pkg.sv
package vpk_pkg;

    typedef enum logic [1:0] {
        EW64 = 2'd0,
        EW32 = 2'd1,
        EW16 = 2'd2,
        EW8  = 2'd3
    } ew_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_TAIL = 2'd2
    } st_e;

endpackage

// File: rtl/vpk_lane_map.sv
// Maps an element index and width onto a register number and byte lanes.
module vpk_lane_map #(
    parameter int REG_W = 64,
    parameter int AW    = 7,
    parameter int IW    = 6
) (
    input  logic [IW-1:0]                idx,
    input  vpk_pkg::ew_e                 ew,
    input  logic [AW-1:0]                base,
    output logic [AW-1:0]                addr,
    output logic [$clog2(REG_W/8)-1:0]   byte_off,
    output logic [REG_W/8-1:0]           be
);
    localparam int NB   = REG_W / 8;
    localparam int LOGW = $clog2(REG_W);
    localparam int PW   = IW + LOGW;

    logic [PW-1:0] bit_pos;
    logic [IW-1:0] reg_off;
    logic [NB-1:0] width_mask;

    always_comb begin
        bit_pos    = PW'(idx) << (LOGW - int'(ew));
        reg_off    = bit_pos[PW-1:LOGW];
        addr       = base + AW'(reg_off);
        byte_off   = bit_pos[LOGW-1:3];
        width_mask = {NB{1'b1}} >> (NB - (NB >> int'(ew)));
        be         = width_mask << byte_off;
    end

endmodule

// File: rtl/vpk_elem_swap.sv
// Optional byte swap at element width, then placement into the element's lanes.
module vpk_elem_swap #(
    parameter int REG_W = 64
) (
    input  logic [REG_W-1:0]             din,
    input  vpk_pkg::ew_e                 ew,
    input  logic                         swap,
    input  logic [$clog2(REG_W/8)-1:0]   byte_off,
    output logic [REG_W-1:0]             lanes
);
    localparam int NB = REG_W / 8;

    logic [REG_W-1:0] elem;

    always_comb begin
        elem = '0;
        for (int b = 0; b < NB; b++) begin
            int nb;
            int src;
            nb  = NB >> int'(ew);
            src = swap ? (nb - 1 - b) : b;
            if (b < nb && src >= 0) begin
                elem[b*8 +: 8] = din[src*8 +: 8];
            end
        end
        lanes = elem << {byte_off, 3'b000};
    end

endmodule

// File: rtl/vec_elem_packer.sv
module vec_elem_packer #(
    parameter  int REG_W  = 64,
    parameter  int REGS   = 128,
    parameter  int MAX_VL = 64,
    localparam int AW     = $clog2(REGS),
    localparam int VLW    = $clog2(MAX_VL + 1),
    localparam int NB     = REG_W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    base_reg,
    input  logic [VLW-1:0]   vec_len,
    input  logic [1:0]       elem_width,
    input  logic             big_endian,
    input  logic             byte_rev_ld,
    input  logic             rev_order,
    input  logic             elem_valid,
    input  logic [REG_W-1:0] elem_data,
    output logic             elem_ready,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [REG_W-1:0] wr_data,
    output logic [NB-1:0]    wr_be,
    output logic             done
);
    import vpk_pkg::*;

    localparam int IW  = $clog2(MAX_VL);
    localparam int BOW = $clog2(NB);

    typedef struct packed {
        st_e              st;
        logic [AW-1:0]    base;
        logic [VLW-1:0]   vl;
        ew_e              ew;
        logic             swap;
        logic             rev;
        logic [VLW-1:0]   cnt;
        logic             wr_en;
        logic [AW-1:0]    wr_addr;
        logic [REG_W-1:0] wr_data;
        logic [NB-1:0]    wr_be;
        logic             done;
    } ctl_t;

    ctl_t r_d, r_q;

    logic [IW-1:0]    cur_idx;
    logic [AW-1:0]    map_addr;
    logic [BOW-1:0]   map_boff;
    logic [NB-1:0]    map_be;
    logic [REG_W-1:0] map_lanes;

    assign cur_idx = r_q.rev ? IW'(r_q.vl - VLW'(1) - r_q.cnt) : IW'(r_q.cnt);

    vpk_lane_map #(.REG_W(REG_W), .AW(AW), .IW(IW)) u_map (
        .idx      (cur_idx),
        .ew       (r_q.ew),
        .base     (r_q.base),
        .addr     (map_addr),
        .byte_off (map_boff),
        .be       (map_be)
    );

    vpk_elem_swap #(.REG_W(REG_W)) u_swap (
        .din      (elem_data),
        .ew       (r_q.ew),
        .swap     (r_q.swap),
        .byte_off (map_boff),
        .lanes    (map_lanes)
    );

    always_comb begin
        r_d       = r_q;
        r_d.wr_en = 1'b0;
        r_d.done  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.base = base_reg;
                    r_d.vl   = vec_len;
                    r_d.ew   = ew_e'(elem_width);
                    r_d.swap = big_endian ^ byte_rev_ld;
                    r_d.rev  = rev_order;
                    r_d.cnt  = '0;
                    if (vec_len == '0) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (elem_valid) begin
                    r_d.wr_en   = 1'b1;
                    r_d.wr_addr = map_addr;
                    r_d.wr_data = map_lanes;
                    r_d.wr_be   = map_be;
                    r_d.cnt     = r_q.cnt + VLW'(1);
                    if (r_q.cnt + VLW'(1) == r_q.vl) begin
                        r_d.st = ST_TAIL;
                    end
                end
            end
            ST_TAIL: begin
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign elem_ready = (r_q.st == ST_RUN);
    assign wr_en      = r_q.wr_en;
    assign wr_addr    = r_q.wr_addr;
    assign wr_data    = r_q.wr_data;
    assign wr_be      = r_q.wr_be;
    assign done       = r_q.done;

    // Input contract: vector length within range when an operation starts.
    a_r9_vl_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (start && r_q.st == ST_IDLE) |-> (vec_len <= VLW'(MAX_VL)));

    a_r4_be_matches_width: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($countones(wr_be) == (NB >> int'(r_q.ew))));

    a_r8_write_needs_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(elem_valid && elem_ready));

    a_r9_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_not_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!wr_en && !elem_ready));

    a_r10_cfg_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_ready && $past(elem_ready)) |-> ($stable(r_q.base) && $stable(r_q.vl)));

endmodule

// File: tb/sim_vec_elem_packer.sv
module sim_vec_elem_packer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  base_reg = '0;
    logic [6:0]  vec_len = '0;
    logic [1:0]  elem_width = '0;
    logic        big_endian = 1'b0;
    logic        byte_rev_ld = 1'b0;
    logic        rev_order = 1'b0;
    logic        elem_valid = 1'b0;
    logic [63:0] elem_data = '0;
    logic        elem_ready;
    logic        wr_en;
    logic [6:0]  wr_addr;
    logic [63:0] wr_data;
    logic [7:0]  wr_be;
    logic        done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    logic [63:0] rf [128];
    logic [63:0] elem_by_idx [64];

    always #2 clk = ~clk;

    vec_elem_packer u0 (
        .clk, .rst_n, .start, .base_reg, .vec_len, .elem_width, .big_endian,
        .byte_rev_ld, .rev_order, .elem_valid, .elem_data, .elem_ready,
        .wr_en, .wr_addr, .wr_data, .wr_be, .done
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mkdata(int op, int k);
        return (64'h9E3779B97F4A7C15 * 64'(op * 97 + k + 1)) ^ (64'(k) << 40);
    endfunction

    function automatic logic [63:0] exp_elem(logic [63:0] d, int ew, bit sw);
        int nb = 8 >> ew;
        logic [63:0] r = '0;
        for (int b = 0; b < nb; b++)
            r[b*8 +: 8] = sw ? d[(nb-1-b)*8 +: 8] : d[b*8 +: 8];
        return r;
    endfunction

    function automatic string wreq(int ew);
        return (ew == 0) ? "R1" : (ew == 1) ? "R2" : "R3";
    endfunction

    task automatic run_op(int op, int base, int vl, int ew, bit be, bit brv,
                          bit rev, bit bubbles, bit poke);
        int  w  = 64 >> ew;
        int  nb = 8 >> ew;
        bit  sw = be ^ brv;
        logic [63:0] mask = (nb == 8) ? '1 : ((64'd1 << (nb*8)) - 1);
        @(negedge clk);
        base_reg = 7'(base); vec_len = 7'(vl); elem_width = 2'(ew);
        big_endian = be; byte_rev_ld = brv; rev_order = rev; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (vl == 0) begin
            chk(done == 1'b1, "R9", "done after empty start", 64'(done), 64'd1);
            chk(wr_en == 1'b0 && elem_ready == 1'b0, "R9", "no write for VL 0",
                64'(wr_en), 64'd0);
            @(negedge clk);
            chk(done == 1'b0, "R9", "done pulse width", 64'(done), 64'd0);
            return;
        end
        for (int k = 0; k < vl; k++) begin
            int idx = rev ? (vl - 1 - k) : k;
            int pos = idx * w;
            int eaddr = (base + pos / 64) % 128;
            int bo = (pos % 64) / 8;
            logic [7:0] ebe = 8'((((1 << nb) - 1) << bo));
            logic [63:0] d = mkdata(op, k);
            logic [63:0] ev = exp_elem(d, ew, sw);
            string rq;
            if (bubbles && (k % 3 == 1)) begin
                elem_valid = 1'b0;
                @(negedge clk);
                chk(wr_en == 1'b0, "R8", "no write without handshake", 64'(wr_en), 64'd0);
            end
            elem_valid = 1'b1;
            elem_data = d;
            if (poke && k == 1) begin
                start = 1'b1; base_reg = 7'(base + 17); vec_len = 7'd2;
                elem_width = 2'(ew ^ 1); rev_order = ~rev;
            end
            while (!elem_ready) @(negedge clk);
            @(negedge clk);
            start = 1'b0;
            elem_by_idx[idx] = ev;
            rq = rev ? "R6" : wreq(ew);
            chk(wr_en == 1'b1, "R8", "write follows handshake", 64'(wr_en), 64'd1);
            chk(wr_addr == 7'(eaddr), (base + pos / 64 >= 128) ? "R7" : rq,
                "register", 64'(wr_addr), 64'(eaddr));
            chk(wr_be == ebe, "R4", "byte enables", 64'(wr_be), 64'(ebe));
            chk(((wr_data >> (bo*8)) & mask) == ev, sw ? "R5" : "R4", "lane data",
                (wr_data >> (bo*8)) & mask, ev);
            for (int b = 0; b < 8; b++)
                if (wr_be[b]) rf[wr_addr][b*8 +: 8] = wr_data[b*8 +: 8];
            if (k < vl - 1) chk(done == 1'b0, "R9", "no early done", 64'(done), 64'd0);
        end
        elem_valid = 1'b0;
        chk(done == 1'b0, "R9", "done not with write", 64'(done), 64'd0);
        @(negedge clk);
        chk(done == 1'b1, "R9", "done after last write", 64'(done), 64'd1);
        chk(wr_en == 1'b0, "R8", "single write per element", 64'(wr_en), 64'd0);
        @(negedge clk);
        chk(done == 1'b0, "R9", "done one cycle", 64'(done), 64'd0);
        // Read back at the same width in index order.
        for (int i = 0; i < vl; i++) begin
            int pos = i * w;
            int ra = (base + pos / 64) % 128;
            logic [63:0] got = (rf[ra] >> (pos % 64)) & mask;
            chk(got == elem_by_idx[i], poke ? "R10" : "R6", "readback",
                got, elem_by_idx[i]);
        end
    endtask

    initial begin
        int op = 0;
        int vls [4] = '{0, 1, 5, 64};
        int bases [2] = '{3, 125};
        for (int i = 0; i < 128; i++) rf[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wr_en == 1'b0 && done == 1'b0 && elem_ready == 1'b0, "R8",
            "reset state", {wr_en, done, elem_ready}, 64'd0);
        for (int ew = 0; ew < 4; ew++)
            for (int m = 0; m < 8; m++)
                for (int vi = 0; vi < 4; vi++)
                    for (int bi = 0; bi < 2; bi++) begin
                        run_op(op, bases[bi], vls[vi], ew, m[0], m[1], m[2],
                               (op % 2) == 1, (op % 5) == 2 && vls[vi] >= 2);
                        op++;
                    end
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !finished) begin
                finished = 1;
                checks++;
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

endmodule